// File: doc/BRIEF.md
# Addressed Serial Receiver with Station Filter

This block receives asynchronous serial characters from a line that several stations share. Each character carries one extra flag bit after its eight data bits. A flag of 1 marks the character as a station address, and a flag of 0 marks it as payload. The receiver holds a station number supplied on an input. It discards all traffic until an address character equal to that number arrives. From then on it passes the payload characters that follow to a valid/ready output, one byte at a time. A different address character ends the selection.

The line is oversampled with a tick input that runs at sixteen times the bit rate. Each bit is taken at the middle of its sixteen-tick period. A start bit that does not last to its midpoint is treated as noise. A character whose stop bit reads low is reported with a one-cycle error pulse and otherwise discarded. A payload byte that completes while the previous byte is still unread is dropped, and a one-cycle overrun pulse reports it. The address character that selects the station is never delivered. A level output shows whether the station is currently selected.

Top module: `mp_rx_station`

## Requirements
- R1: The line idles high. A character is a low start bit, eight data bits sent least significant first, a flag bit, and a high stop bit. A delivered byte has the first data bit received in out_data[0] and the last in out_data[7].
- R2: Each bit is sampled at mid-period, counting ticks from the first tick that sees the line low. If the line is high again at the middle of the start bit, nothing is received and the receiver waits for the next falling edge.
- R3: The bit after the eighth data bit is the flag: 1 means address, 0 means payload. No parity bit is present.
- R4: While selected is 0, payload characters are discarded and out_valid stays 0.
- R5: An address character equal to station_id sets selected to 1. That address byte does not appear on out_data and does not raise out_valid.
- R6: An address character not equal to station_id clears selected. The payload characters that follow are discarded.
- R7: A character whose stop bit samples low produces a one-cycle framing_err pulse. It leaves selected, out_valid and out_data unchanged.
- R8: An accepted payload byte raises out_valid. out_valid and out_data hold until the first cycle in which out_valid and out_ready are both 1. After that cycle out_valid is 0.
- R9: A payload character that completes while out_valid is 1, and not in a handshake cycle, produces a one-cycle overrun pulse. The new byte is dropped and the held byte is kept.
- R10: While enable is 0, the receiver ignores the line and selected is 0.
- R11: After reset, out_valid, selected, framing_err and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver enable |
| rx | input | 1 | Serial line, idle high |
| tick | input | 1 | One-cycle strobe at 16x the bit rate |
| station_id | input | 8 | Address of this station |
| out_data | output | 8 | Received payload byte |
| out_valid | output | 1 | Payload byte held and unread |
| out_ready | input | 1 | Consumer takes the held byte |
| selected | output | 1 | Station currently addressed |
| framing_err | output | 1 | One-cycle pulse on a low stop bit |
| overrun | output | 1 | One-cycle pulse when a payload byte is dropped |

## Verification
The hardest condition to reach from the ports is a second payload character that completes while the first is still unread. Reaching it requires the station to be selected first and the consumer to hold out_ready low across a whole character time. The stimulus therefore selects the station, sends two payload characters back to back without reading, and then checks that the overrun pulse occurred and that the first byte survived. Noise on the start bit and a low stop bit are made the same way: the bench drives the line directly for a chosen number of tick periods.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;

    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int CNT_W  = $clog2(OVS);
    localparam int NBITS  = DATA_W + 1;
    localparam int NB_W   = $clog2(NBITS + 1);

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_BITS  = 2'd2,
        LN_STOP  = 2'd3
    } line_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] payload;
        logic              is_addr;
        logic              stop_ok;
    } rx_char_t;

    function automatic logic at_count(input logic [CNT_W-1:0] c, input int lim);
        return c == CNT_W'(lim - 1);
    endfunction

endpackage

// File: rtl/mp_rx_deframer.sv
module mp_rx_deframer
    import mp_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     rx,
    input  logic     tick,
    output logic     char_done,
    output rx_char_t char_q
);

    logic [1:0]        sync_q;
    line_state_t       st;
    logic [CNT_W-1:0]  cnt;
    logic [NB_W-1:0]   nbit;
    logic [NBITS-1:0]  shreg;
    logic              rx_s;

    assign rx_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rx};
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st        <= LN_IDLE;
            cnt       <= '0;
            nbit      <= '0;
            shreg     <= '0;
            char_done <= 1'b0;
            char_q    <= '0;
        end else begin
            char_done <= 1'b0;
            if (tick) begin
                unique case (st)
                    LN_IDLE: begin
                        if (!rx_s) begin
                            st  <= LN_START;
                            cnt <= '0;
                        end
                    end
                    LN_START: begin
                        if (at_count(cnt, OVS/2)) begin
                            cnt  <= '0;
                            nbit <= '0;
                            st   <= rx_s ? LN_IDLE : LN_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    LN_BITS: begin
                        if (at_count(cnt, OVS)) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[NBITS-1:1]};
                            if (nbit == NB_W'(NBITS - 1)) st <= LN_STOP;
                            else                          nbit <= nbit + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    LN_STOP: begin
                        if (at_count(cnt, OVS)) begin
                            cnt             <= '0;
                            st              <= LN_IDLE;
                            char_done       <= 1'b1;
                            char_q.payload  <= shreg[DATA_W-1:0];
                            char_q.is_addr  <= shreg[NBITS-1];
                            char_q.stop_ok  <= rx_s;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= LN_IDLE;
                endcase
            end
        end
    end

    AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
        char_done |=> !char_done); // R1

    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(char_done) |-> $past(st == LN_STOP)); // R2

endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter
    import mp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              char_done,
    input  rx_char_t          char_q,
    input  logic [DATA_W-1:0] station_id,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              selected,
    output logic              framing_err,
    output logic              overrun
);

    logic pop;
    assign pop = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data    <= '0;
            out_valid   <= 1'b0;
            selected    <= 1'b0;
            framing_err <= 1'b0;
            overrun     <= 1'b0;
        end else begin
            framing_err <= 1'b0;
            overrun     <= 1'b0;
            if (pop) out_valid <= 1'b0;
            if (!enable) begin
                selected <= 1'b0;
            end else if (char_done) begin
                if (!char_q.stop_ok) begin
                    framing_err <= 1'b1;
                end else if (char_q.is_addr) begin
                    selected <= (char_q.payload == station_id);
                end else if (selected) begin
                    if (out_valid && !pop) begin
                        overrun <= 1'b1;
                    end else begin
                        out_data  <= char_q.payload;
                        out_valid <= 1'b1;
                    end
                end
            end
        end
    end

    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_OVR_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(out_valid)); // R9

    AST_LOAD_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(selected)); // R4

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(framing_err && overrun)); // R7

    AST_DESEL_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !selected); // R10

endmodule

// File: rtl/mp_rx_station.sv
module mp_rx_station
    import mp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              rx,
    input  logic              tick,
    input  logic [DATA_W-1:0] station_id,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              selected,
    output logic              framing_err,
    output logic              overrun
);

    logic     char_done;
    rx_char_t char_q;

    mp_rx_deframer u_deframer (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .rx        (rx),
        .tick      (tick),
        .char_done (char_done),
        .char_q    (char_q)
    );

    mp_rx_filter u_filter (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .char_done   (char_done),
        .char_q      (char_q),
        .station_id  (station_id),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .selected    (selected),
        .framing_err (framing_err),
        .overrun     (overrun)
    );

endmodule

// File: tb/sim_mp_rx_station.sv
`timescale 1ns/1ps
module sim_mp_rx_station;

    localparam int TDIV   = 2;
    localparam int BITCLK = 16 * TDIV;
    localparam logic [7:0] MY_ID = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       rx = 1'b1;
    logic       tick;
    logic       tc = 1'b0;
    logic [7:0] station_id = MY_ID;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       selected;
    logic       framing_err;
    logic       overrun;

    int n_run = 0;
    int n_fail = 0;
    int ferr_cnt = 0;
    int ovr_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) tc <= ~tc;
    assign tick = tc;

    always @(posedge clk) begin
        if (framing_err) ferr_cnt <= ferr_cnt + 1;
        if (overrun)     ovr_cnt  <= ovr_cnt + 1;
    end

    mp_rx_station u0 (
        .clk(clk), .rst(rst), .enable(enable), .rx(rx), .tick(tick),
        .station_id(station_id), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .selected(selected),
        .framing_err(framing_err), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clocks);
        rx = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic addr, input logic good_stop);
        hold_line(1'b0, BITCLK);
        for (int b = 0; b < 8; b++) hold_line(d[b], BITCLK);
        hold_line(addr, BITCLK);
        if (good_stop) hold_line(1'b1, BITCLK);
        else           hold_line(1'b0, 10 * TDIV);
        hold_line(1'b1, 2 * BITCLK);
    endtask

    task automatic pop_byte();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 0 && selected == 0, "R11 reset outputs", {out_valid, selected}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(framing_err == 0 && overrun == 0, "R11 error pulses idle", {framing_err, overrun}, 0);

        // R4: payload while unselected is dropped
        send_char(8'h33, 1'b0, 1'b1);
        chk(out_valid == 0, "R4 unselected payload dropped", out_valid, 0);

        // R5: matching address selects, not delivered
        send_char(MY_ID, 1'b1, 1'b1);
        chk(selected == 1, "R5 match selects", selected, 1);
        chk(out_valid == 0, "R5 address byte not delivered", out_valid, 0);

        // R1 R3 R8: sweep payload values, LSB first
        for (int v = 0; v < 256; v += 3) begin
            send_char(8'(v), 1'b0, 1'b1);
            chk(out_valid == 1, "R8 payload raises valid", out_valid, 1);
            chk(out_data == 8'(v), "R1 payload bit order", out_data, v);
            repeat (5) @(negedge clk);
            chk(out_valid == 1 && out_data == 8'(v), "R8 held until read", out_data, v);
            pop_byte();
            chk(out_valid == 0, "R8 cleared after handshake", out_valid, 0);
        end

        // R6: every single-bit miss deselects and blocks payload
        for (int k = 0; k < 8; k++) begin
            send_char(MY_ID ^ (8'h01 << k), 1'b1, 1'b1);
            chk(selected == 0, "R6 mismatch deselects", selected, 0);
            send_char(8'hC3, 1'b0, 1'b1);
            chk(out_valid == 0, "R6 payload skipped after mismatch", out_valid, 0);
            send_char(MY_ID, 1'b1, 1'b1);
            chk(selected == 1, "R5 reselect", selected, 1);
        end

        // R3: a byte equal to the ID with flag 0 is payload
        send_char(MY_ID, 1'b0, 1'b1);
        chk(out_valid == 1 && out_data == MY_ID, "R3 flag 0 is payload", out_data, MY_ID);
        pop_byte();

        // R2: short start pulse is noise
        begin
            int f0 = ferr_cnt;
            hold_line(1'b0, 4 * TDIV);
            hold_line(1'b1, 3 * BITCLK);
            chk(out_valid == 0 && ferr_cnt == f0, "R2 start glitch ignored", out_valid, 0);
            send_char(8'h96, 1'b0, 1'b1);
            chk(out_valid == 1 && out_data == 8'h96, "R2 receive after glitch", out_data, 8'h96);
            pop_byte();
        end

        // R7: bad stop bit
        begin
            int f0 = ferr_cnt;
            send_char(8'h11, 1'b0, 1'b0);
            chk(ferr_cnt == f0 + 1, "R7 framing pulse", ferr_cnt - f0, 1);
            chk(out_valid == 0, "R7 bad frame not delivered", out_valid, 0);
            send_char(8'h00, 1'b1, 1'b0);
            chk(selected == 1, "R7 bad address frame leaves selection", selected, 1);
        end

        // R9: overrun
        begin
            int o0 = ovr_cnt;
            send_char(8'hA1, 1'b0, 1'b1);
            send_char(8'hB2, 1'b0, 1'b1);
            chk(ovr_cnt == o0 + 1, "R9 overrun pulse", ovr_cnt - o0, 1);
            chk(out_valid == 1 && out_data == 8'hA1, "R9 old byte kept", out_data, 8'hA1);
            pop_byte();
            chk(out_valid == 0, "R9 new byte dropped", out_valid, 0);
        end

        // R10: disable
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk(selected == 0, "R10 disable deselects", selected, 0);
        send_char(MY_ID, 1'b1, 1'b1);
        chk(selected == 0, "R10 line ignored while off", selected, 0);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        send_char(MY_ID, 1'b1, 1'b1);
        send_char(8'h7E, 1'b0, 1'b1);
        chk(out_valid == 1 && out_data == 8'h7E, "R10 works after re-enable", out_data, 8'h7E);
        pop_byte();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule